// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target has left stuck, with SDA held low partway through a byte. It works only through two open-drain override controls. Asserting an override pulls its line low, and releasing it lets the pull-up bring the line high. It reads the real SCL and SDA levels back from the pads. A microsecond tick from the clock domain sets every delay.

A one-cycle start command begins the sequence. The block first sends a one-cycle soft-reset pulse to the normal controller and waits 5 µs for it to settle. It then clocks SCL, 5 µs low and 5 µs released per pulse, until the target lets go of SDA. After the clocking it builds a STOP on the raw lines: both lines low, then SCL released while SDA stays low, then SDA released. If the bus could not be freed, the block resets the controller a second time and polls its status byte for the idle code. The outcome is reported as a one-cycle done pulse and a held result code.

All pins are plain control and status signals. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_bus_rescue`

## Requirements
- R1: A start command accepted while idle produces exactly one `ctrl_srst_o` pulse of one cycle. Both overrides then stay released for 5 microsecond ticks of settling.
- R2: If SCL and SDA both read high at the end of settling, no SCL pulse is issued and the sequence moves straight to the STOP.
- R3: Each SCL pulse holds `scl_ovr_o` high for 5 ticks and then releases it for 5 ticks. SDA is sampled at the end of the released half, and pulsing stops as soon as SDA reads high.
- R4: If SCL still reads low at the end of a released half, pulsing stops at once and the bus counts as not freed.
- R5: At most 9 SCL pulses are issued. If SDA is still low after the 9th, the bus counts as not freed.
- R6: The STOP asserts both overrides for 5 ticks, then holds only `sda_ovr_o` for 5 ticks, then releases SDA. `sda_ovr_o` is never asserted or released while `scl_ovr_o` is deasserted and asserted respectively, in the wrong order.
- R7: When the bus was not freed, a second `ctrl_srst_o` pulse follows the STOP. `ctrl_stat_i` is then checked once per tick for up to 10 checks. Seeing 8'hF8 gives result 2, and never seeing it gives result 3.
- R8: `done_o` is a one-cycle pulse with both overrides released. `result_o` changes only together with `done_o` and takes these codes: 0 none since reset, 1 bus freed, 2 controller reinitialised, 3 reinitialisation failed.
- R9: A start command that arrives while a sequence is running is ignored. It causes no extra soft-reset pulse and no change in the pulse count.
- R10: Reset releases both overrides, clears `result_o` to 0 and holds `done_o` and `ctrl_srst_o` low. After reset the block does nothing until a new start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin recovery |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| scl_in_i | input | 1 | Sampled SCL pad level |
| sda_in_i | input | 1 | Sampled SDA pad level |
| ctrl_stat_i | input | 8 | Status byte of the normal controller |
| scl_ovr_o | output | 1 | Pull SCL low when high |
| sda_ovr_o | output | 1 | Pull SDA low when high |
| ctrl_srst_o | output | 1 | One-cycle soft reset to the controller |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| result_o | output | 2 | Outcome code, held until the next done |

## Verification
Some properties are checked on every cycle:
- the order of the override edges that form the STOP;
- the single-cycle done pulse and that both lines are released when it fires;
- that `result_o` moves only with `done_o`;
- that a soft reset never coincides with a pulled line;
- a bound on the number of SCL pulses in one sequence.

Other behaviour can only be shown by the bench's scenarios, which model a target holding SDA for a chosen number of clocks, a stuck SCL and a controller that becomes idle after a chosen delay. These scenarios cover the exact tick counts of each phase, the choice between early stop and the pulse limit, the result codes of the reinitialisation path, and that a start arriving while busy is ignored.

// File: rtl/rescue_pkg.sv
package rescue_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETTLE,
    S_LOW,
    S_HIGH,
    S_STOPA,
    S_STOPB,
    S_CHECK
  } rescue_state_t;

  typedef enum logic [1:0] {
    RES_NONE      = 2'd0,
    RES_FREED     = 2'd1,
    RES_REINIT_OK = 2'd2,
    RES_REINIT_BAD= 2'd3
  } rescue_result_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rescue_timer.sv
module rescue_timer #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (load_i)                      cnt_q <= len_i;
    else if (tick_i && cnt_q != '0)       cnt_q <= cnt_q - TW'(1);
  end
endmodule

// File: rtl/rescue_count.sv
module rescue_count #(
  parameter int LIMIT = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] q;

  assign last_o = (q == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr_i)  q <= '0;
    else if (inc_i)  q <= q + W'(1);
  end
endmodule

// File: rtl/i2c_bus_rescue.sv
module i2c_bus_rescue
  import rescue_pkg::*;
#(
  parameter int          SETTLE_US  = 5,
  parameter int          HALF_US    = 5,
  parameter int          STOP_US    = 5,
  parameter int          CHECK_US   = 1,
  parameter int          MAX_PULSES = 9,
  parameter int          MAX_CHECKS = 10,
  parameter int          STAT_W     = 8,
  parameter logic [7:0]  IDLE_CODE  = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              us_tick_i,
  input  logic              scl_in_i,
  input  logic              sda_in_i,
  input  logic [STAT_W-1:0] ctrl_stat_i,
  output logic              scl_ovr_o,
  output logic              sda_ovr_o,
  output logic              ctrl_srst_o,
  output logic              done_o,
  output logic [1:0]        result_o
);
  localparam int LONGEST = max2(max2(SETTLE_US, HALF_US), max2(STOP_US, CHECK_US));
  localparam int TW      = $clog2(LONGEST + 1);

  rescue_state_t st_q, st_n;
  logic          ok_q, ok_n;
  logic          ld;
  logic [TW-1:0] len;
  logic          expire;
  logic          p_clr, p_inc, p_last;
  logic          c_clr, c_inc, c_last;
  logic          fin, srst_n;
  logic [1:0]    res_n;

  rescue_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .len_i(len),
    .tick_i(us_tick_i), .expire_o(expire)
  );

  rescue_count #(.LIMIT(MAX_PULSES)) pulse_ctr_i (
    .clk(clk), .rst_n(rst_n), .clr_i(p_clr), .inc_i(p_inc), .last_o(p_last)
  );

  rescue_count #(.LIMIT(MAX_CHECKS)) check_ctr_i (
    .clk(clk), .rst_n(rst_n), .clr_i(c_clr), .inc_i(c_inc), .last_o(c_last)
  );

  always_comb begin
    st_n   = st_q;
    ok_n   = ok_q;
    ld     = 1'b0;
    len    = '0;
    p_clr  = 1'b0;
    p_inc  = 1'b0;
    c_clr  = 1'b0;
    c_inc  = 1'b0;
    fin    = 1'b0;
    srst_n = 1'b0;
    res_n  = RES_NONE;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_n = S_SETTLE; ld = 1'b1; len = TW'(SETTLE_US);
        p_clr = 1'b1; srst_n = 1'b1; ok_n = 1'b0;
      end
      S_SETTLE: if (expire) begin
        ld = 1'b1;
        if (scl_in_i && sda_in_i) begin
          st_n = S_STOPA; len = TW'(STOP_US); ok_n = 1'b1;
        end else begin
          st_n = S_LOW; len = TW'(HALF_US);
        end
      end
      S_LOW: if (expire) begin
        st_n = S_HIGH; ld = 1'b1; len = TW'(HALF_US);
      end
      S_HIGH: if (expire) begin
        ld = 1'b1;
        if (!scl_in_i) begin
          st_n = S_STOPA; len = TW'(STOP_US); ok_n = 1'b0;
        end else if (sda_in_i) begin
          st_n = S_STOPA; len = TW'(STOP_US); ok_n = 1'b1;
        end else if (p_last) begin
          st_n = S_STOPA; len = TW'(STOP_US); ok_n = 1'b0;
        end else begin
          st_n = S_LOW; len = TW'(HALF_US); p_inc = 1'b1;
        end
      end
      S_STOPA: if (expire) begin
        st_n = S_STOPB; ld = 1'b1; len = TW'(STOP_US);
      end
      S_STOPB: if (expire) begin
        if (ok_q) begin
          st_n = S_IDLE; fin = 1'b1; res_n = RES_FREED;
        end else begin
          st_n = S_CHECK; ld = 1'b1; len = TW'(CHECK_US);
          c_clr = 1'b1; srst_n = 1'b1;
        end
      end
      S_CHECK: if (expire) begin
        if (ctrl_stat_i == STAT_W'(IDLE_CODE)) begin
          st_n = S_IDLE; fin = 1'b1; res_n = RES_REINIT_OK;
        end else if (c_last) begin
          st_n = S_IDLE; fin = 1'b1; res_n = RES_REINIT_BAD;
        end else begin
          ld = 1'b1; len = TW'(CHECK_US); c_inc = 1'b1;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      ok_q        <= 1'b0;
      scl_ovr_o   <= 1'b0;
      sda_ovr_o   <= 1'b0;
      ctrl_srst_o <= 1'b0;
      done_o      <= 1'b0;
      result_o    <= RES_NONE;
    end else begin
      st_q        <= st_n;
      ok_q        <= ok_n;
      scl_ovr_o   <= (st_n == S_LOW) || (st_n == S_STOPA);
      sda_ovr_o   <= (st_n == S_STOPA) || (st_n == S_STOPB);
      ctrl_srst_o <= srst_n;
      done_o      <= fin;
      if (fin) result_o <= res_n;
    end
  end
endmodule

// File: rtl/rescue_checker.sv
module rescue_checker #(
  parameter int MAX_PULSES = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_ovr_o,
  input logic       sda_ovr_o,
  input logic       ctrl_srst_o,
  input logic       done_o,
  input logic [1:0] result_o
);
  localparam int RW = $clog2(MAX_PULSES + 3);
  logic [RW-1:0] rises;
  logic          scl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises <= '0;
      scl_d <= 1'b0;
    end else begin
      scl_d <= scl_ovr_o;
      if (ctrl_srst_o || done_o)        rises <= '0;
      else if (scl_ovr_o && !scl_d)     rises <= rises + RW'(1);
    end
  end

  assert_release_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!scl_ovr_o && !sda_ovr_o));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_result_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_o);

  assert_stop_release_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_ovr_o) |-> !scl_ovr_o);

  assert_sda_pull_with_scl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_ovr_o) |-> scl_ovr_o);

  assert_srst_lines_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_srst_o |-> (!scl_ovr_o && !sda_ovr_o));

  assert_pulse_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rises <= RW'(MAX_PULSES + 1));
endmodule

bind i2c_bus_rescue rescue_checker #(.MAX_PULSES(MAX_PULSES)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_ovr_o(scl_ovr_o), .sda_ovr_o(sda_ovr_o),
  .ctrl_srst_o(ctrl_srst_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/i2c_bus_rescue_tb.sv
module i2c_bus_rescue_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] stat;
  logic       scl_ov, sda_ov, srst, done;
  logic [1:0] result;
  logic       scl_line, sda_line;

  int  hold = 0;
  bit  stuck = 1'b0;
  int  g_idle = 0;
  int  tcnt = 0;
  int  total = 0, bad = 0, cycles = 0;

  bit  meas = 1'b0;
  bit  any_ov = 1'b0;
  int  srst_cnt = 0, settle_t = 0, low_t = 0, both_t = 0, sda_t = 0, rises = 0;

  always #10 clk = ~clk;

  assign scl_line = !scl_ov && !stuck;
  assign sda_line = !sda_ov && (hold == 0);
  assign stat     = (tcnt >= g_idle) ? 8'hF8 : 8'h20;

  i2c_bus_rescue dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .us_tick_i(tick),
    .scl_in_i(scl_line), .sda_in_i(sda_line), .ctrl_stat_i(stat),
    .scl_ovr_o(scl_ov), .sda_ovr_o(sda_ov), .ctrl_srst_o(srst),
    .done_o(done), .result_o(result)
  );

  // target model: lets go of SDA after hold SCL rising edges
  always @(posedge scl_line) if (hold > 0) hold = hold - 1;

  // microsecond tick: one cycle high every 8 cycles
  initial begin
    forever begin
      repeat (7) @(posedge clk);
      #1 tick = 1'b1;
      @(posedge clk);
      #1 tick = 1'b0;
    end
  end

  always @(negedge clk) begin
    tcnt = srst ? (tick ? 1 : 0) : tcnt + (tick ? 1 : 0);
    if (meas) begin
      if (scl_ov || sda_ov) any_ov = 1'b1;
      if (srst) srst_cnt++;
      if (tick) begin
        if (srst_cnt >= 1 && !any_ov) settle_t++;
        if (scl_ov && !sda_ov) low_t++;
        if (scl_ov && sda_ov)  both_t++;
        if (!scl_ov && sda_ov) sda_t++;
      end
    end
  end

  always @(posedge scl_ov) if (meas) rises++;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: run did not finish act=%0d exp=<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_meas();
    any_ov = 1'b0; srst_cnt = 0; settle_t = 0; low_t = 0;
    both_t = 0; sda_t = 0; rises = 0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  // returns result code, or -1 on timeout
  task automatic wait_done(output int res, output int ovs);
    int n = 0;
    res = -1; ovs = -1;
    while (n < 5000) begin
      @(negedge clk);
      if (done) begin
        res = result; ovs = {scl_ov, sda_ov};
        break;
      end
      n++;
    end
  endtask

  // packed vector: hold[19:16] stuck[15] idle_delay[14:10] result[9:8] pulses[7:4]
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {4'd0,  1'b0, 5'd0,  2'd1, 4'd0, 4'd0},
    {4'd1,  1'b0, 5'd0,  2'd1, 4'd1, 4'd0},
    {4'd4,  1'b0, 5'd0,  2'd1, 4'd4, 4'd0},
    {4'd9,  1'b0, 5'd0,  2'd1, 4'd9, 4'd0},
    {4'd10, 1'b0, 5'd3,  2'd2, 4'd9, 4'd0},
    {4'd12, 1'b0, 5'd10, 2'd2, 4'd9, 4'd0},
    {4'd15, 1'b0, 5'd11, 2'd3, 4'd9, 4'd0},
    {4'd3,  1'b1, 5'd2,  2'd2, 4'd1, 4'd0},
    {4'd0,  1'b1, 5'd31, 2'd3, 4'd1, 4'd0},
    {4'd0,  1'b0, 5'd0,  2'd1, 4'd0, 4'd0}
  };

  initial begin
    int res, ovs;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 scl override in reset", scl_ov, 0);
    chk("R10 sda override in reset", sda_ov, 0);
    chk("R10 result in reset", result, 0);
    chk("R10 done/srst in reset", {done, srst}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      int exp_res, exp_p;
      hold   = VEC[i][19:16];
      stuck  = VEC[i][15];
      g_idle = VEC[i][14:10];
      exp_res = VEC[i][9:8];
      exp_p   = VEC[i][7:4];
      repeat (3) @(posedge clk);
      clear_meas();
      meas = 1'b1;
      pulse_start();
      wait_done(res, ovs);
      meas = 1'b0;
      chk($sformatf("R8 result vec%0d", i), res, exp_res);
      chk($sformatf("R8 lines free at done vec%0d", i), ovs, 0);
      chk($sformatf("R1 settle ticks vec%0d", i), settle_t, 5);
      chk($sformatf("R3 R4 R5 pulse count vec%0d", i), rises - 1, exp_p);
      chk($sformatf("R3 low ticks vec%0d", i), low_t, 5 * exp_p);
      chk($sformatf("R6 both-low ticks vec%0d", i), both_t, 5);
      chk($sformatf("R6 sda-only ticks vec%0d", i), sda_t, 5);
      chk($sformatf("R7 srst pulses vec%0d", i), srst_cnt, (exp_res == 1) ? 1 : 2);
      if (exp_p == 0) chk($sformatf("R2 no pulse vec%0d", i), low_t, 0);
      stuck = 1'b0;
      hold  = 0;
    end

    // R9: start while busy is ignored
    hold = 3; stuck = 1'b0;
    repeat (3) @(posedge clk);
    clear_meas();
    meas = 1'b1;
    pulse_start();
    repeat (30) @(posedge clk);
    pulse_start();
    repeat (100) @(posedge clk);
    pulse_start();
    wait_done(res, ovs);
    meas = 1'b0;
    chk("R9 result with extra starts", res, 1);
    chk("R9 srst count with extra starts", srst_cnt, 1);
    chk("R9 pulse count with extra starts", rises - 1, 3);

    // R10: reset in mid-sequence
    hold = 15;
    repeat (3) @(posedge clk);
    pulse_start();
    begin
      int n = 0;
      while (!scl_ov && n < 2000) begin @(negedge clk); n++; end
    end
    chk("R10 override active before reset", scl_ov, 1);
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R10 overrides released by reset", {scl_ov, sda_ov}, 0);
    chk("R10 result cleared by reset", result, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    hold = 0;
    clear_meas();
    meas = 1'b1;
    repeat (200) @(posedge clk);
    meas = 1'b0;
    chk("R10 idle after reset: srst", srst_cnt, 0);
    chk("R10 idle after reset: scl pulls", rises, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule